// File: doc/BRIEF.md
# Delayed-Branch Resume Address Resolver

When an exception is raised while a delayed branch is executing, the instruction that actually faulted is the one in the delay slot, not the branch. This block looks at the 16-bit word held at the current PC and works out two things. The first is the address of the instruction that really faulted. The second is the PC at which execution must resume. For a delayed branch, the faulting instruction sits at PC+2 and execution resumes at the branch target. For any other word, the faulting instruction is the word itself and execution resumes at PC+2.

The caller presents the word, the PC, the T flag, the procedure (return-address) register and a general-register value on an input-valid strobe. The block reads one general register through a combinational read port. The register index is taken from bits 11:8 of the word. For subroutine-call forms it also produces a procedure-register update of PC+4. All results are captured in a register stage and appear one cycle after the strobe. A flag marks whether a delay-slot branch was found.

Top module: `slot_branch_resolver`

## Requirements
- R1: After reset, `out_valid`, `slot_flag` and `link_we` are 0.
- R2: Words with bits 15:12 equal to 0xA or 0xB resume at PC + 4 + 2 × (bits 11:0 sign-extended), with the sum taken modulo 2^AW.
- R3: Words with bits 15:8 equal to 0x8D resume at PC + 4 + 2 × (bits 7:0 sign-extended) when T is 1, and at PC + 4 when T is 0. For bits 15:8 equal to 0x8F the T condition is inverted.
- R4: Words matching 0x4n0B or 0x4n2B resume at the value of general register n. `gpr_sel` always equals bits 11:8 of `insn`.
- R5: Words matching 0x0n03 or 0x0n23 resume at PC + 4 + the value of general register n.
- R6: The word 0x000B resumes at `link_in`.
- R7: Words with bits 15:12 equal to 0xB, and words matching 0x4n0B, give `link_we` = 1 and `link_val` = PC + 4. Every other word gives `link_we` = 0.
- R8: For every form in R2–R6, `slot_flag` = 1 and `fault_addr` = PC + 2. For any other word, `slot_flag` = 0, `fault_addr` = PC and `resume_pc` = PC + 2.
- R9: Results appear with `out_valid` = 1 exactly one cycle after `in_valid`. In a cycle without `in_valid`, `out_valid` is 0, `link_we` is 0, and `slot_flag`, `fault_addr` and `resume_pc` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| insn | input | 16 | Instruction word at the current PC |
| pc | input | AW | Current PC |
| t_flag | input | 1 | T condition flag |
| link_in | input | AW | Current procedure register |
| gpr_sel | output | 4 | General-register read index |
| gpr_data | input | AW | General-register value for `gpr_sel`, same cycle |
| out_valid | output | 1 | Results valid |
| slot_flag | output | 1 | A delay-slot branch was found |
| fault_addr | output | AW | Address of the faulting instruction |
| resume_pc | output | AW | PC at which execution resumes |
| link_we | output | 1 | Procedure-register update strobe |
| link_val | output | AW | New procedure-register value |

## Verification
The assertions assume that `gpr_data` answers `gpr_sel` within the same cycle. They also assume that `pc`, `link_in` and `insn` are stable around the strobe edge. The bench meets both conditions: it derives the register value combinationally from the index as a fixed arithmetic function, and it changes every input only at the falling edge. Every one of the 65536 words is strobed back to back, with varying PC, T and procedure-register values. A few directed words follow, covering address wrap and the hold behaviour.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_DISP  = 3'd1,
    BK_CONDT = 3'd2,
    BK_CONDF = 3'd3,
    BK_RABS  = 3'd4,
    BK_RREL  = 3'd5,
    BK_RET   = 3'd6
  } br_kind_e;
endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
  import sbr_pkg::*;
(
  input  logic [15:0] insn,
  output br_kind_e    kind,
  output logic        is_call
);
  logic [3:0] nb3, nb2, nb1, nb0;

  always_comb begin
    nb3 = insn[15:12];
    nb2 = insn[11:8];
    nb1 = insn[7:4];
    nb0 = insn[3:0];
  end

  always_comb begin
    kind = BK_NONE;
    if (nb3 == 4'hA || nb3 == 4'hB)
      kind = BK_DISP;
    else if (nb3 == 4'h8 && nb2 == 4'hD)
      kind = BK_CONDT;
    else if (nb3 == 4'h8 && nb2 == 4'hF)
      kind = BK_CONDF;
    else if (nb3 == 4'h4 && nb0 == 4'hB && (nb1 == 4'h0 || nb1 == 4'h2))
      kind = BK_RABS;
    else if (nb3 == 4'h0 && nb0 == 4'h3 && (nb1 == 4'h0 || nb1 == 4'h2))
      kind = BK_RREL;
    else if (insn == 16'h000B)
      kind = BK_RET;
  end

  always_comb begin
    is_call = (nb3 == 4'hB) || (nb3 == 4'h4 && nb1 == 4'h0 && nb0 == 4'hB);
  end
endmodule

// File: rtl/sbr_target.sv
module sbr_target
  import sbr_pkg::*;
#(
  parameter int AW = 32
) (
  input  br_kind_e      kind,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] pc,
  input  logic          t_flag,
  input  logic [AW-1:0] link_in,
  input  logic [AW-1:0] gpr_data,
  output logic          slot,
  output logic [AW-1:0] fault,
  output logic [AW-1:0] resume,
  output logic [AW-1:0] pc_plus4
);
  localparam int D12W = 12;
  localparam int D8W  = 8;

  logic [AW-1:0] pc_plus2;
  logic [AW-1:0] off12;
  logic [AW-1:0] off8;
  logic          take;

  always_comb begin
    pc_plus2 = pc + AW'(2);
    pc_plus4 = pc + AW'(4);
    off12    = {{(AW-D12W-1){insn[D12W-1]}}, insn[D12W-1:0], 1'b0};
    off8     = {{(AW-D8W-1){insn[D8W-1]}}, insn[D8W-1:0], 1'b0};
    take     = (kind == BK_CONDT) ? t_flag : !t_flag;
  end

  always_comb begin
    slot = (kind != BK_NONE);
    unique case (kind)
      BK_DISP:           resume = pc_plus4 + off12;
      BK_CONDT, BK_CONDF: resume = take ? (pc_plus4 + off8) : pc_plus4;
      BK_RABS:           resume = gpr_data;
      BK_RREL:           resume = pc_plus4 + gpr_data;
      BK_RET:            resume = link_in;
      default:           resume = pc_plus2;
    endcase
    fault = slot ? pc_plus2 : pc;
  end
endmodule

// File: rtl/sbr_outreg.sv
module sbr_outreg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          slot_d,
  input  logic [AW-1:0] fault_d,
  input  logic [AW-1:0] resume_d,
  input  logic          call_d,
  input  logic [AW-1:0] link_d,
  output logic          valid_q,
  output logic          slot_q,
  output logic [AW-1:0] fault_q,
  output logic [AW-1:0] resume_q,
  output logic          call_q,
  output logic [AW-1:0] link_q
);
  logic          slot_n;
  logic [AW-1:0] fault_n;
  logic [AW-1:0] resume_n;
  logic [AW-1:0] link_n;

  always_comb begin
    slot_n   = en ? slot_d   : slot_q;
    fault_n  = en ? fault_d  : fault_q;
    resume_n = en ? resume_d : resume_q;
    link_n   = en ? link_d   : link_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      slot_q   <= 1'b0;
      fault_q  <= '0;
      resume_q <= '0;
      call_q   <= 1'b0;
      link_q   <= '0;
    end else begin
      valid_q  <= en;
      call_q   <= en & call_d;
      slot_q   <= slot_n;
      fault_q  <= fault_n;
      resume_q <= resume_n;
      link_q   <= link_n;
    end
  end
endmodule

// File: rtl/slot_branch_resolver.sv
module slot_branch_resolver
  import sbr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   insn,
  input  logic [AW-1:0] pc,
  input  logic          t_flag,
  input  logic [AW-1:0] link_in,
  output logic [3:0]    gpr_sel,
  input  logic [AW-1:0] gpr_data,
  output logic          out_valid,
  output logic          slot_flag,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] resume_pc,
  output logic          link_we,
  output logic [AW-1:0] link_val
);
  br_kind_e      kind;
  logic          is_call;
  logic          slot_c;
  logic [AW-1:0] fault_c;
  logic [AW-1:0] resume_c;
  logic [AW-1:0] pc4_c;

  assign gpr_sel = insn[11:8];

  sbr_decode u_dec (
    .insn    (insn),
    .kind    (kind),
    .is_call (is_call)
  );

  sbr_target #(.AW(AW)) u_tgt (
    .kind     (kind),
    .insn     (insn),
    .pc       (pc),
    .t_flag   (t_flag),
    .link_in  (link_in),
    .gpr_data (gpr_data),
    .slot     (slot_c),
    .fault    (fault_c),
    .resume   (resume_c),
    .pc_plus4 (pc4_c)
  );

  sbr_outreg #(.AW(AW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_valid),
    .slot_d   (slot_c),
    .fault_d  (fault_c),
    .resume_d (resume_c),
    .call_d   (is_call),
    .link_d   (pc4_c),
    .valid_q  (out_valid),
    .slot_q   (slot_flag),
    .fault_q  (fault_addr),
    .resume_q (resume_pc),
    .call_q   (link_we),
    .link_q   (link_val)
  );
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [15:0]   insn,
  input logic [AW-1:0] pc,
  input logic          t_flag,
  input logic [AW-1:0] link_in,
  input logic [3:0]    gpr_sel,
  input logic [AW-1:0] gpr_data,
  input logic          out_valid,
  input logic          slot_flag,
  input logic [AW-1:0] fault_addr,
  input logic [AW-1:0] resume_pc,
  input logic          link_we,
  input logic [AW-1:0] link_val
);
  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !link_we));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(slot_flag) && $stable(fault_addr) && $stable(resume_pc)));

  a_r8_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (fault_addr == $past(pc) + (slot_flag ? AW'(2) : AW'(0))));

  a_r8_plain_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !slot_flag) |-> (resume_pc == fault_addr + AW'(2)));

  a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (slot_flag && link_val == fault_addr + AW'(2)));

  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insn == 16'h000B) |=> (resume_pc == $past(link_in)));

  a_r4_select: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (gpr_sel == insn[11:8]));
endmodule

bind slot_branch_resolver sbr_checker #(.AW(AW)) u_chk (.*);

// File: tb/test_slot_branch_resolver.sv
module test_slot_branch_resolver;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [15:0]   insn;
  logic [AW-1:0] pc;
  logic          t_flag;
  logic [AW-1:0] link_in;
  logic [3:0]    gpr_sel;
  logic [AW-1:0] gpr_data;
  logic          out_valid;
  logic          slot_flag;
  logic [AW-1:0] fault_addr;
  logic [AW-1:0] resume_pc;
  logic          link_we;
  logic [AW-1:0] link_val;

  int total;
  int bad;

  slot_branch_resolver #(.AW(AW)) i_slot_branch_resolver (.*);

  function automatic logic [AW-1:0] gval(input logic [3:0] idx);
    return 32'h1234_0000 ^ (32'(idx) * 32'h0011_1111);
  endfunction

  assign gpr_data = gval(gpr_sel);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected results for one word
  logic          e_slot, e_call;
  logic [AW-1:0] e_fault, e_resume, e_link;
  string         e_tag;

  task automatic model(input logic [15:0] w, input logic [AW-1:0] p,
                       input logic t, input logic [AW-1:0] lk);
    logic signed [AW-1:0] d12, d8;
    d12 = AW'(signed'(w[11:0]));
    d8  = AW'(signed'(w[7:0]));
    e_slot = 1'b1;
    if (w[15:12] == 4'hA || w[15:12] == 4'hB) begin
      e_resume = p + 4 + d12 * 2; e_tag = "R2";
    end else if (w[15:8] == 8'h8D) begin
      e_resume = t ? p + 4 + d8 * 2 : p + 4; e_tag = "R3";
    end else if (w[15:8] == 8'h8F) begin
      e_resume = !t ? p + 4 + d8 * 2 : p + 4; e_tag = "R3";
    end else if (w[15:12] == 4'h4 && w[3:0] == 4'hB && (w[7:4] == 4'h0 || w[7:4] == 4'h2)) begin
      e_resume = gval(w[11:8]); e_tag = "R4";
    end else if (w[15:12] == 4'h0 && w[3:0] == 4'h3 && (w[7:4] == 4'h0 || w[7:4] == 4'h2)) begin
      e_resume = p + 4 + gval(w[11:8]); e_tag = "R5";
    end else if (w == 16'h000B) begin
      e_resume = lk; e_tag = "R6";
    end else begin
      e_resume = p + 2; e_slot = 1'b0; e_tag = "R8";
    end
    e_fault = e_slot ? p + 2 : p;
    e_call  = (w[15:12] == 4'hB) || (w[15:12] == 4'h4 && w[7:0] == 8'h0B);
    e_link  = p + 4;
  endtask

  task automatic check_out(input logic [15:0] w);
    logic ok;
    total++;
    ok = out_valid && slot_flag == e_slot && fault_addr == e_fault &&
         resume_pc == e_resume && link_we == e_call && (!e_call || link_val == e_link);
    if (!ok) begin
      bad++;
      $display("FAIL %s/R7/R8/R9 word=%h got v=%b s=%b f=%h r=%h lw=%b lv=%h exp s=%b f=%h r=%h lw=%b lv=%h",
               e_tag, w, out_valid, slot_flag, fault_addr, resume_pc, link_we, link_val,
               e_slot, e_fault, e_resume, e_call, e_link);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [AW-1:0] p,
                       input logic t, input logic [AW-1:0] lk);
    in_valid = 1'b1; insn = w; pc = p; t_flag = t; link_in = lk;
    model(w, p, t, lk);
  endtask

  initial begin : watchdog
    #1500000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] last_w;
    logic [AW-1:0] hold_f, hold_r;
    logic hold_s;
    total = 0; bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; insn = '0; pc = '0; t_flag = 1'b0; link_in = '0;
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || slot_flag !== 1'b0 || link_we !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset got v=%b s=%b lw=%b exp 0 0 0", out_valid, slot_flag, link_we);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8 R9: every word, strobed back to back
    last_w = '0;
    for (int i = 0; i < 65536; i++) begin
      if (i != 0) check_out(last_w);
      last_w = 16'(i);
      drive(16'(i), 32'h4000_0000 + 32'(i) * 32'd6, i[0] ^ i[9], 32'h2000_0000 + 32'(i) * 32'd4);
      total++;
      #1;
      if (gpr_sel !== insn[11:8]) begin
        bad++;
        $display("FAIL R4 gpr_sel got %h exp %h", gpr_sel, insn[11:8]);
      end
      @(negedge clk);
    end
    check_out(last_w);

    // R2 wrap modulo 2^AW, R3 both polarities, R6 return
    drive(16'hA000, 32'hFFFF_FFFC, 1'b0, 32'h0);            @(negedge clk); check_out(16'hA000);
    drive(16'hAFFF, 32'h0000_0000, 1'b0, 32'h0);            @(negedge clk); check_out(16'hAFFF);
    drive(16'h8D80, 32'h0000_1000, 1'b1, 32'h0);            @(negedge clk); check_out(16'h8D80);
    drive(16'h8F80, 32'h0000_1000, 1'b1, 32'h0);            @(negedge clk); check_out(16'h8F80);
    drive(16'h000B, 32'h0000_2000, 1'b0, 32'hCAFE_0010);    @(negedge clk); check_out(16'h000B);

    // R9: no strobe, inputs change, outputs hold
    hold_s = slot_flag; hold_f = fault_addr; hold_r = resume_pc;
    in_valid = 1'b0; insn = 16'hB123; pc = 32'h7777_0000; link_in = 32'h1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0 || link_we !== 1'b0 || slot_flag !== hold_s ||
          fault_addr !== hold_f || resume_pc !== hold_r) begin
        bad++;
        $display("FAIL R9 hold got v=%b lw=%b s=%b f=%h r=%h exp v=0 lw=0 s=%b f=%h r=%h",
                 out_valid, link_we, slot_flag, fault_addr, resume_pc, hold_s, hold_f, hold_r);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule